// File: doc/BRIEF.md
# UART Buffered-Mode Line Status Unit

This block holds the line status word of a serial port whose receive and transmit directions both go through FIFOs. It is meant for software that polls the status word rather than waiting for interrupts. Completed receive characters enter a 16-entry FIFO. Each entry keeps its own parity, framing and break tags beside the data byte, so error reporting stays tied to the right character. The block also follows the occupancy of the transmit FIFO and whether the transmit shift register is busy. It latches receive overrun, and it keeps a sticky summary flag for errors anywhere in the receive FIFO.

The block also decides, separately for each direction, whether that direction runs polled. A direction runs polled when the FIFO-enable control is set and that direction's interrupt-enable bits are all clear. In polled mode the receive trigger-level indication is held low, but both FIFOs keep buffering characters as usual. The block does not cover serial bit timing, baud generation or the ranking of interrupt sources.

Top module: `uart_fifo_lsr`

## Requirements
- R1: Status bit 0 (data ready) is 1 whenever the receive FIFO holds one or more characters, and 0 when it is empty.
- R2: A character that completes while the receive FIFO is full, with no receive-buffer read in that cycle, is discarded and sets status bit 1 (overrun) on the next cycle. Bit 1 clears after a status read unless a new overrun occurs in the same cycle.
- R3: Status bits 2, 3 and 4 give the parity, framing and break tags of the character at the FIFO head. They change when that character is popped, and they read 0 when the FIFO is empty.
- R4: Status bit 5 is 1 exactly when the transmit FIFO holds no characters.
- R5: Status bit 6 is 1 exactly when the transmit FIFO is empty and the transmit shift register is idle.
- R6: Status bit 7 is set on the cycle after a character carrying any tag enters the receive FIFO. A status read clears it only when no entry left in the FIFO after that cycle carries a tag. Otherwise it stays set.
- R7: Receive is polled when fifo_en is 1 and ier bits 0 and 2 are both 0. Transmit is polled when fifo_en is 1 and ier bit 1 is 0. Each direction is judged independently.
- R8: rx_trig is 1 when fifo_en is 1, receive is not polled, and the receive occupancy has reached the level chosen by trig_sel (0:1, 1:4, 2:8, 3:14 entries). In polled mode it is always 0, while the FIFO keeps buffering.
- R9: The receive FIFO is first-in first-out. rbr_data shows the head byte, or 0 when the FIFO is empty. A read of an empty FIFO has no effect.
- R10: A synchronous reset empties both FIFOs, idles the shift register, sets status bits 5 and 6, and clears every other status bit.
- R11: A transmit write when the transmit FIFO already holds 16 characters is ignored. A shift-register load is accepted only when the FIFO is not empty, and it marks the shifter busy. tx_done clears busy unless a load is accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_en | input | 1 | FIFO-enable control bit |
| ier | input | 4 | Interrupt-enable bits (0 rx data, 1 tx empty, 2 rx line status, 3 modem) |
| trig_sel | input | 2 | Receive trigger level select |
| rx_valid | input | 1 | A received character completes this cycle |
| rx_data | input | 8 | Received character |
| rx_perr | input | 1 | Parity error tag of the received character |
| rx_ferr | input | 1 | Framing error tag of the received character |
| rx_brk | input | 1 | Break tag of the received character |
| rbr_rd | input | 1 | Receive buffer read (pops the head) |
| lsr_rd | input | 1 | Status word read |
| tx_push | input | 1 | Software writes a character into the transmit FIFO |
| tx_load | input | 1 | Shift register takes the next character from the transmit FIFO |
| tx_done | input | 1 | Shift register finished its character |
| lsr | output | 8 | Line status word |
| rbr_data | output | 8 | Byte at the receive FIFO head |
| rx_polled | output | 1 | Receive direction runs polled |
| tx_polled | output | 1 | Transmit direction runs polled |
| rx_trig | output | 1 | Receive trigger level reached (interrupt mode only) |

## Verification
A wrong pointer or occupancy count shows up on the very next cycle, either as the wrong head byte on rbr_data or as bits 2 to 4 describing the wrong character. A miscounted tag tally does not show up at once. It appears only when a later status read clears bit 7 too early or leaves it set too long, which can be many cycles after the fault. For that reason the stimulus mixes tagged characters with status reads while entries are still queued. Transmit occupancy errors show up in bits 5 and 6 only when the count should reach zero or should stop at 16. The bench therefore fills the transmit FIFO past its limit and drains it to empty.

// File: rtl/uart_lsr_pkg.sv
package uart_lsr_pkg;

  localparam int unsigned CHAR_W = 8;

  // One receive FIFO entry: the byte plus its three error tags
  typedef struct packed {
    logic              brk;
    logic              ferr;
    logic              perr;
    logic [CHAR_W-1:0] data;
  } rx_ent_t;

  // Any tag present on an entry
  function automatic logic ent_bad(rx_ent_t e);
    return e.brk | e.ferr | e.perr;
  endfunction

  // Trigger threshold in entries, scaled to the FIFO depth
  function automatic int unsigned trig_level(logic [1:0] sel, int unsigned depth);
    case (sel)
      2'd0:    return 1;
      2'd1:    return depth / 4;
      2'd2:    return depth / 2;
      default: return depth - 2;
    endcase
  endfunction

  // Circular pointer advance for any depth
  function automatic int unsigned ptr_next(int unsigned p, int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

  // Status word assembly; bit positions are what software decodes
  function automatic logic [7:0] lsr_pack(logic ready, logic ovr, logic perr,
                                          logic ferr, logic brk, logic tx_empty,
                                          logic all_idle, logic err_sum);
    return {err_sum, all_idle, tx_empty, brk, ferr, perr, ovr, ready};
  endfunction

endpackage

// File: rtl/lsr_rx_fifo.sv
module lsr_rx_fifo
  import uart_lsr_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1),
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_req,
  input  rx_ent_t       push_ent,
  input  logic          pop_req,
  output rx_ent_t       head_ent,
  output logic [CW-1:0] count,
  output logic [CW-1:0] err_cnt,
  output logic [CW-1:0] err_cnt_nxt,
  output logic          push_evt,
  output logic          push_bad,
  output logic          pop_evt,
  output logic          ovr_evt
);

  rx_ent_t       mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          full, empty, pop_bad;
  logic [CW-1:0] count_nxt;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

  // A read in the same cycle frees the slot for a completing character
  assign pop_evt  = pop_req & ~empty;
  assign push_evt = push_req & (~full | pop_evt);
  assign ovr_evt  = push_req & full & ~pop_evt;
  assign push_bad = push_evt & ent_bad(push_ent);
  assign pop_bad  = pop_evt & ent_bad(head_ent);

  assign head_ent = mem[rd_ptr];

  always_comb begin
    count_nxt = count;
    if (push_evt) count_nxt = count_nxt + CW'(1);
    if (pop_evt)  count_nxt = count_nxt - CW'(1);
    err_cnt_nxt = err_cnt;
    if (push_bad) err_cnt_nxt = err_cnt_nxt + CW'(1);
    if (pop_bad)  err_cnt_nxt = err_cnt_nxt - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (push_evt) mem[wr_ptr] <= push_ent;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      err_cnt <= '0;
    end else begin
      if (push_evt) wr_ptr <= PW'(ptr_next(int'(wr_ptr), DEPTH));
      if (pop_evt)  rd_ptr <= PW'(ptr_next(int'(rd_ptr), DEPTH));
      count   <= count_nxt;
      err_cnt <= err_cnt_nxt;
    end
  end

  AST_RX_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH)); // R9

  AST_OVR_HOLDS_COUNT: assert property (@(posedge clk) disable iff (rst)
    ovr_evt |=> count == $past(count)); // R2

  AST_ERR_WITHIN_COUNT: assert property (@(posedge clk) disable iff (rst)
    err_cnt <= count); // R6

endmodule

// File: rtl/lsr_tx_track.sv
module lsr_tx_track #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_req,
  input  logic          load_req,
  input  logic          done,
  output logic [CW-1:0] count,
  output logic          busy,
  output logic          load_evt
);

  logic push_evt;

  assign push_evt = push_req & (count != CW'(DEPTH));
  assign load_evt = load_req & (count != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      busy  <= 1'b0;
    end else begin
      count <= count + CW'(push_evt) - CW'(load_evt);
      if (load_evt)  busy <= 1'b1;
      else if (done) busy <= 1'b0;
    end
  end

  AST_TX_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH)); // R11

  AST_TX_LOAD_BUSY: assert property (@(posedge clk) disable iff (rst)
    load_evt |=> busy); // R11

endmodule

// File: rtl/lsr_mode_dec.sv
module lsr_mode_dec
  import uart_lsr_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          fifo_en,
  input  logic [3:0]    ier,
  input  logic [1:0]    trig_sel,
  input  logic [CW-1:0] rx_count,
  output logic          rx_polled,
  output logic          tx_polled,
  output logic          rx_trig
);

  logic [CW-1:0] level;

  // Receive data and receive line status enables belong to the rx path
  assign rx_polled = fifo_en & ~ier[0] & ~ier[2];
  assign tx_polled = fifo_en & ~ier[1];

  assign level   = CW'(trig_level(trig_sel, DEPTH));
  assign rx_trig = fifo_en & ~rx_polled & (rx_count >= level);

endmodule

// File: rtl/uart_fifo_lsr.sv
module uart_fifo_lsr
  import uart_lsr_pkg::*;
#(
  parameter int unsigned RX_DEPTH = 16,
  parameter int unsigned TX_DEPTH = 16,
  localparam int unsigned RCW = $clog2(RX_DEPTH + 1),
  localparam int unsigned TCW = $clog2(TX_DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        fifo_en,
  input  logic [3:0]  ier,
  input  logic [1:0]  trig_sel,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_perr,
  input  logic        rx_ferr,
  input  logic        rx_brk,
  input  logic        rbr_rd,
  input  logic        lsr_rd,
  input  logic        tx_push,
  input  logic        tx_load,
  input  logic        tx_done,
  output logic [7:0]  lsr,
  output logic [7:0]  rbr_data,
  output logic        rx_polled,
  output logic        tx_polled,
  output logic        rx_trig
);

  rx_ent_t        in_ent, head_ent;
  logic [RCW-1:0] rx_count, err_cnt, err_cnt_nxt;
  logic [TCW-1:0] tx_count;
  logic           push_evt, push_bad, pop_evt, ovr_evt;
  logic           tx_busy, tx_load_evt;
  logic           rx_nonempty, ovr_flag, err_sum;

  assign in_ent = '{brk: rx_brk, ferr: rx_ferr, perr: rx_perr, data: rx_data};

  lsr_rx_fifo #(.DEPTH(RX_DEPTH)) u_rx (
    .clk(clk), .rst(rst),
    .push_req(rx_valid), .push_ent(in_ent), .pop_req(rbr_rd),
    .head_ent(head_ent), .count(rx_count),
    .err_cnt(err_cnt), .err_cnt_nxt(err_cnt_nxt),
    .push_evt(push_evt), .push_bad(push_bad),
    .pop_evt(pop_evt), .ovr_evt(ovr_evt)
  );

  lsr_tx_track #(.DEPTH(TX_DEPTH)) u_tx (
    .clk(clk), .rst(rst),
    .push_req(tx_push), .load_req(tx_load), .done(tx_done),
    .count(tx_count), .busy(tx_busy), .load_evt(tx_load_evt)
  );

  lsr_mode_dec #(.DEPTH(RX_DEPTH)) u_mode (
    .fifo_en(fifo_en), .ier(ier), .trig_sel(trig_sel), .rx_count(rx_count),
    .rx_polled(rx_polled), .tx_polled(tx_polled), .rx_trig(rx_trig)
  );

  assign rx_nonempty = (rx_count != '0);

  // Sticky status: a new event wins over the read that would clear it
  always_ff @(posedge clk) begin
    if (rst) begin
      ovr_flag <= 1'b0;
      err_sum  <= 1'b0;
    end else begin
      if (ovr_evt)     ovr_flag <= 1'b1;
      else if (lsr_rd) ovr_flag <= 1'b0;
      if (push_bad)                               err_sum <= 1'b1;
      else if (lsr_rd && err_cnt_nxt == '0)       err_sum <= 1'b0;
    end
  end

  assign lsr = lsr_pack(rx_nonempty, ovr_flag,
                        rx_nonempty & head_ent.perr,
                        rx_nonempty & head_ent.ferr,
                        rx_nonempty & head_ent.brk,
                        tx_count == '0,
                        (tx_count == '0) & ~tx_busy,
                        err_sum);

  assign rbr_data = rx_nonempty ? head_ent.data : '0;

  AST_OVR_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    ovr_evt |=> lsr[1]); // R2

  AST_HEAD_TAGS_EMPTY: assert property (@(posedge clk) disable iff (rst)
    !lsr[0] |-> lsr[4:2] == 3'b000); // R3

  AST_ERRSUM_COVERS: assert property (@(posedge clk) disable iff (rst)
    err_cnt != '0 |-> lsr[7]); // R6

  AST_TAG_SETS_SUM: assert property (@(posedge clk) disable iff (rst)
    push_bad |=> lsr[7]); // R6

  AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (rst)
    pop_evt && !push_evt |=> rx_count == $past(rx_count) - RCW'(1)); // R9

  AST_TEMT_NEEDS_IDLE: assert property (@(posedge clk) disable iff (rst)
    tx_load_evt |=> !lsr[6]); // R5

endmodule

// File: tb/sim_uart_fifo_lsr.sv
module sim_uart_fifo_lsr;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fifo_en = 1'b0;
  logic [3:0] ier = '0;
  logic [1:0] trig_sel = '0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rx_perr = 1'b0, rx_ferr = 1'b0, rx_brk = 1'b0;
  logic       rbr_rd = 1'b0, lsr_rd = 1'b0;
  logic       tx_push = 1'b0, tx_load = 1'b0, tx_done = 1'b0;
  logic [7:0] lsr, rbr_data;
  logic       rx_polled, tx_polled, rx_trig;

  uart_fifo_lsr u0 (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .ier(ier), .trig_sel(trig_sel),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_perr(rx_perr),
    .rx_ferr(rx_ferr), .rx_brk(rx_brk), .rbr_rd(rbr_rd), .lsr_rd(lsr_rd),
    .tx_push(tx_push), .tx_load(tx_load), .tx_done(tx_done),
    .lsr(lsr), .rbr_data(rbr_data), .rx_polled(rx_polled),
    .tx_polled(tx_polled), .rx_trig(rx_trig)
  );

  always #5 clk = ~clk;

  // Reference model state
  logic [10:0] rxq[$];   // {brk, ferr, perr, data}
  bit          m_ovr, m_sum, m_busy;
  int          m_txn;
  int          vectors = 0, fails = 0;
  bit          finished = 0;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lvl(logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  task automatic compare();
    bit ne, rxp, txp;
    ne  = rxq.size() > 0;
    rxp = fifo_en && !ier[0] && !ier[2];
    txp = fifo_en && !ier[1];
    chk("R1 data ready", lsr[0], ne);
    chk("R2 overrun", lsr[1], m_ovr);
    chk("R3 head parity", lsr[2], ne ? rxq[0][8] : 1'b0);
    chk("R3 head framing", lsr[3], ne ? rxq[0][9] : 1'b0);
    chk("R3 head break", lsr[4], ne ? rxq[0][10] : 1'b0);
    chk("R4 R11 tx fifo empty", lsr[5], m_txn == 0);
    chk("R5 transmitter idle", lsr[6], m_txn == 0 && !m_busy);
    chk("R6 error summary", lsr[7], m_sum);
    chk("R9 head byte", rbr_data, ne ? rxq[0][7:0] : 8'h00);
    chk("R7 rx polled", rx_polled, rxp);
    chk("R7 tx polled", tx_polled, txp);
    chk("R8 trigger", rx_trig, fifo_en && !rxp && rxq.size() >= lvl(trig_sel));
  endtask

  task automatic model_edge();
    bit pop, push, ovr, ld;
    int bad;
    if (rst) begin
      rxq.delete(); m_ovr = 0; m_sum = 0; m_busy = 0; m_txn = 0;
      return;
    end
    pop  = rbr_rd && rxq.size() > 0;
    push = rx_valid && (rxq.size() < 16 || pop);
    ovr  = rx_valid && rxq.size() == 16 && !pop;
    if (pop)  void'(rxq.pop_front());
    if (push) rxq.push_back({rx_brk, rx_ferr, rx_perr, rx_data});
    bad = 0;
    foreach (rxq[i]) if (rxq[i][10:8] != 3'b000) bad++;
    if (ovr) m_ovr = 1; else if (lsr_rd) m_ovr = 0;
    if (push && (rx_perr || rx_ferr || rx_brk)) m_sum = 1;
    else if (lsr_rd && bad == 0) m_sum = 0;
    ld = tx_load && m_txn > 0;
    if (tx_push && m_txn < 16) m_txn++;
    if (ld) m_txn--;
    if (ld) m_busy = 1; else if (tx_done) m_busy = 0;
  endtask

  function automatic bit pick(int pct);
    return ($urandom % 100) < pct;
  endfunction

  // One cycle: drive after the falling edge, compare, then advance the model
  task automatic run(int n, int prx, int prd, int plsr, int perr,
                     int ptp, int pld, int pdn, int prst);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rst      = pick(prst);
      rx_valid = pick(prx);
      rx_data  = 8'($urandom);
      rx_perr  = pick(perr);
      rx_ferr  = pick(perr);
      rx_brk   = pick(perr / 2);
      rbr_rd   = pick(prd);
      lsr_rd   = pick(plsr);
      tx_push  = pick(ptp);
      tx_load  = pick(pld);
      tx_done  = pick(pdn);
      if (pick(10)) begin
        fifo_en  = pick(70);
        ier      = 4'($urandom);
        trig_sel = 2'($urandom);
      end
      #1 compare();
      @(posedge clk);
      model_edge();
    end
  endtask

  initial begin
    // R10: hold reset, then check the reset state
    repeat (2) @(posedge clk);
    model_edge();
    @(negedge clk);
    #1 compare();
    chk("R10 reset status word", lsr, 8'h60);
    @(posedge clk);
    // R1 R2 R8: fill past 16 to force overrun, no reads
    fifo_en = 1'b1; ier = 4'b0001; trig_sel = 2'd3;
    run(24, 90, 0, 0, 0, 0, 0, 0, 0);
    // R2: status reads clear overrun
    run(4, 0, 0, 100, 0, 0, 0, 0, 0);
    // R9: drain in order, then read while empty
    run(24, 0, 90, 0, 0, 0, 0, 0, 0);
    // R3 R6: tagged characters with reads of both kinds
    run(300, 50, 40, 30, 25, 0, 0, 0, 0);
    // R11: overfill tx, then drain and idle shifter
    run(24, 0, 0, 0, 0, 90, 0, 0, 0);
    run(30, 0, 0, 0, 0, 0, 80, 50, 0);
    // R7 R8: mode and level changes with rx traffic
    run(400, 45, 35, 20, 10, 40, 40, 40, 0);
    // mixed traffic with occasional reset (R10)
    run(3000, 50, 45, 25, 15, 50, 45, 40, 1);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule